// File: doc/BRIEF.md
# Configuration Codeword Unpacker and Steerer

This block sits on a 24-bit configuration write bus made of 16 address wires and 8 data wires. While idle it watches for one write to a control address, and the data byte of that write gives the number of address/data pairs that will follow in compressed form. It then owns the whole bus. Every bus word is treated as 24 bits of codeword stream, `{bus_addr, bus_data}`, and the word is split into two 12-bit chunks that are consumed high chunk first.

Two kinds of codeword share the stream, and no tag bit marks which kind comes next. An address codeword is 24 bits long and may straddle two bus words. A data codeword is 12 bits long. The block keeps two running totals of values described so far, one for addresses and one for data. Whenever the data total is below the address total, the next codeword is data. Otherwise the next codeword is an address.

Each finished codeword goes into a small FIFO in front of its expander. Bus control returns to idle once both totals have reached the pair count. The sender avoids overrunning the FIFOs by inserting all-ones no-op words, and any codeword that still meets a full FIFO is dropped and raises a sticky error.

Top module: `cfgcw_unpacker`

## Requirements
- R1: After reset, `dec_active`, `acw_valid`, `dcw_valid` and `ovf_err` are all low.
- R2: While idle, a write to address `CTRL_ADDR` (default 16'hFFF0) with a nonzero data byte raises `dec_active` from the next cycle and loads that byte as the pair count. A start write with a zero byte, and every other write made while idle, leaves the block idle and produces no codeword.
- R3: While active, each bus write forms the word W = {bus_addr, bus_data}. W[23:12] is consumed as the first 12-bit chunk and W[11:0] as the second.
- R4: Both totals are zero at start. Before each codeword, if the data total is less than the address total, the next codeword is a data codeword (one chunk). Otherwise it is an address codeword of two chunks, with the earlier chunk forming bits [23:12]. The two chunks may come from consecutive bus words.
- R5: An address codeword adds (bits [7:3] + 1) to the address total. A data codeword adds (bits [3:1] + 1) to the data total.
- R6: An all-ones bus word that arrives while no address half is pending is discarded. It produces no codeword and leaves both totals unchanged.
- R7: Once a chunk leaves both totals at or above the pair count with no address half pending, `dec_active` is low after that bus word. Any remaining chunk of that word is discarded.
- R8: Each output FIFO holds `FIFO_DEPTH` codewords and delivers them in arrival order. Valid is high while the FIFO is not empty, a codeword is removed when valid and ready are both high, and a codeword that is not taken stays unchanged.
- R9: A codeword that meets a full FIFO is dropped and sets `ovf_err`. A pop in the same cycle frees a slot first. `ovf_err` stays set until the next start.
- R10: Two data codewords taken from one bus word are both stored, and they are stored in chunk order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 16 | Address wires, upper 16 codeword-stream bits when active |
| bus_data | input | 8 | Data wires, lower 8 codeword-stream bits when active |
| dec_active | output | 1 | Block owns the bus |
| acw_valid | output | 1 | Address codeword available |
| acw_data | output | 24 | Address codeword |
| acw_ready | input | 1 | Address expander takes the codeword |
| dcw_valid | output | 1 | Data codeword available |
| dcw_data | output | 12 | Data codeword |
| dcw_ready | input | 1 | Data expander takes the codeword |
| ovf_err | output | 1 | Sticky codeword-dropped flag |

## Verification
Two functions can fall in the same cycle:
- **Pop into a full FIFO while a new codeword arrives.** The data expander holds its ready low until its FIFO is full. It then raises ready in the very cycle the next data codeword arrives. The bench judges the case by `ovf_err` staying low and by all four data codewords coming out in order.
- **End of run with a chunk left over.** The pair count is reached on the first chunk of a word. The bench then checks that the second chunk never appears at any output and that `dec_active` has fallen.

// File: rtl/cfgcw_pkg.sv
package cfgcw_pkg;
    localparam int ABUS_W   = 16;
    localparam int DBUS_W   = 8;
    localparam int WORD_W   = ABUS_W + DBUS_W;
    localparam int HALF_W   = WORD_W / 2;
    localparam int ACW_W    = WORD_W;
    localparam int DCW_W    = HALF_W;
    localparam int ALEN_LSB = 3;
    localparam int ALEN_W   = 5;
    localparam int DLEN_LSB = 1;
    localparam int DLEN_W   = 3;
    localparam int CNT_W    = DBUS_W;
    localparam int ACC_W    = CNT_W + 2;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ACW_W-1:0]  acw_t;
    typedef logic [DCW_W-1:0]  dcw_t;
    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {ST_IDLE, ST_RUN} mode_e;

    typedef struct packed {
        logic  pend;
        half_t held;
        acc_t  a_tot;
        acc_t  d_tot;
    } track_t;

    function automatic acc_t acw_span(acw_t cw);
        return acc_t'(cw[ALEN_LSB +: ALEN_W]) + acc_t'(1);
    endfunction

    function automatic acc_t dcw_span(dcw_t cw);
        return acc_t'(cw[DLEN_LSB +: DLEN_W]) + acc_t'(1);
    endfunction

    function automatic logic want_data(acc_t a_tot, acc_t d_tot);
        return d_tot < a_tot;
    endfunction
endpackage

// File: rtl/cfgcw_fifo.sv
module cfgcw_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   push_n,
    input  logic [W-1:0] wdata0,
    input  logic [W-1:0] wdata1,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] rdata,
    output logic         ovf
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CW:0]      count;
    logic [CW:0]      free_n, acc_n, push_ext;
    logic             pop;

    assign valid    = (count != '0);
    assign rdata    = mem[rd_ptr];
    assign pop      = valid && ready;
    assign push_ext = (CW+1)'(push_n);
    assign free_n   = (CW+1)'(DEPTH) - count + (CW+1)'(pop);
    assign ovf      = push_ext > free_n;
    assign acc_n    = ovf ? free_n : push_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if ((CW+1)'(k) < acc_n)
                    mem[PTR_W'(wr_ptr + PTR_W'(k))] <= (k == 0) ? wdata0 : wdata1;
            end
            wr_ptr <= PTR_W'(wr_ptr + PTR_W'(acc_n));
            if (pop) rd_ptr <= PTR_W'(rd_ptr + PTR_W'(1));
            count <= count + acc_n - (CW+1)'(pop);
        end
    end

    assert_fifo_depth_R8: assert property (@(posedge clk) disable iff (rst)
        count <= (CW+1)'(DEPTH));
    assert_fifo_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(rdata)));
endmodule

// File: rtl/cfgcw_steer.sv
module cfgcw_steer
    import cfgcw_pkg::*;
#(
    parameter logic [ABUS_W-1:0] CTRL_ADDR = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ABUS_W-1:0] bus_addr,
    input  logic [DBUS_W-1:0] bus_data,
    input  logic              ovf_a,
    input  logic              ovf_d,
    output logic              active,
    output logic              a_push,
    output acw_t              a_word,
    output logic [1:0]        d_push_n,
    output dcw_t              d_word0,
    output dcw_t              d_word1,
    output logic              ovf_err
);
    mode_e  mode;
    track_t cur, nx;
    cnt_t   pair_cnt;
    acc_t   cnt_ext;
    word_t  word;
    half_t  chunk;
    dcw_t   dw [2];
    logic   done, noop, start;

    assign word    = {bus_addr, bus_data};
    assign active  = (mode == ST_RUN);
    assign cnt_ext = acc_t'(pair_cnt);
    assign start   = (mode == ST_IDLE) && bus_wr && (bus_addr == CTRL_ADDR) && (bus_data != '0);
    assign noop    = (word == '1) && !cur.pend;
    assign d_word0 = dw[0];
    assign d_word1 = dw[1];

    always_comb begin
        nx       = cur;
        done     = 1'b0;
        a_push   = 1'b0;
        a_word   = '0;
        d_push_n = 2'd0;
        dw[0]    = '0;
        dw[1]    = '0;
        chunk    = '0;
        if (mode == ST_RUN && bus_wr && !noop) begin
            for (int i = 0; i < 2; i++) begin
                chunk = (i == 0) ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
                if (!done) begin
                    if (nx.pend) begin
                        a_word   = {nx.held, chunk};
                        a_push   = 1'b1;
                        nx.a_tot = nx.a_tot + acw_span({nx.held, chunk});
                        nx.pend  = 1'b0;
                    end else if (want_data(nx.a_tot, nx.d_tot)) begin
                        dw[d_push_n[0]] = chunk;
                        d_push_n        = d_push_n + 2'd1;
                        nx.d_tot        = nx.d_tot + dcw_span(chunk);
                    end else begin
                        nx.held = chunk;
                        nx.pend = 1'b1;
                    end
                    if (!nx.pend && nx.a_tot >= cnt_ext && nx.d_tot >= cnt_ext)
                        done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= ST_IDLE;
            cur      <= '0;
            pair_cnt <= '0;
            ovf_err  <= 1'b0;
        end else begin
            if (ovf_a || ovf_d) ovf_err <= 1'b1;
            case (mode)
                ST_IDLE: if (start) begin
                    mode     <= ST_RUN;
                    pair_cnt <= bus_data;
                    cur      <= '0;
                    ovf_err  <= 1'b0;
                end
                ST_RUN: begin
                    cur <= nx;
                    if (done) mode <= ST_IDLE;
                end
                default: mode <= ST_IDLE;
            endcase
        end
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_IDLE && !start) |=> (mode == ST_IDLE));
    assert_totals_zero_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (cur.a_tot == '0 && cur.d_tot == '0 && !cur.pend));
    assert_noop_still_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_RUN && bus_wr && word == '1 && !cur.pend) |=> ($stable(cur.a_tot) && $stable(cur.d_tot)));
    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_IDLE) |-> (!a_push && d_push_n == 2'd0));
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_err && !start) |=> ovf_err);
endmodule

// File: rtl/cfgcw_unpacker.sv
module cfgcw_unpacker
    import cfgcw_pkg::*;
#(
    parameter logic [15:0] CTRL_ADDR  = 16'hFFF0,
    parameter int          FIFO_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_data,
    output logic        dec_active,
    output logic        acw_valid,
    output logic [23:0] acw_data,
    input  logic        acw_ready,
    output logic        dcw_valid,
    output logic [11:0] dcw_data,
    input  logic        dcw_ready,
    output logic        ovf_err
);
    logic       a_push, ovf_a, ovf_d;
    acw_t       a_word;
    logic [1:0] d_push_n;
    dcw_t       d_word0, d_word1;

    cfgcw_steer #(.CTRL_ADDR(CTRL_ADDR)) u_steer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data),
        .ovf_a(ovf_a), .ovf_d(ovf_d), .active(dec_active),
        .a_push(a_push), .a_word(a_word), .d_push_n(d_push_n),
        .d_word0(d_word0), .d_word1(d_word1), .ovf_err(ovf_err)
    );

    cfgcw_fifo #(.W(ACW_W), .DEPTH(FIFO_DEPTH)) u_afifo (
        .clk(clk), .rst(rst), .push_n({1'b0, a_push}), .wdata0(a_word), .wdata1('0),
        .ready(acw_ready), .valid(acw_valid), .rdata(acw_data), .ovf(ovf_a)
    );

    cfgcw_fifo #(.W(DCW_W), .DEPTH(FIFO_DEPTH)) u_dfifo (
        .clk(clk), .rst(rst), .push_n(d_push_n), .wdata0(d_word0), .wdata1(d_word1),
        .ready(dcw_ready), .valid(dcw_valid), .rdata(dcw_data), .ovf(ovf_d)
    );
endmodule

// File: tb/test_cfgcw_unpacker.sv
module test_cfgcw_unpacker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        acw_ready = 1'b1, dcw_ready = 1'b1;
    logic        dec_active, acw_valid, dcw_valid, ovf_err;
    logic [23:0] acw_data;
    logic [11:0] dcw_data;
    int vectors = 0, miscompares = 0;
    logic [23:0] aq[$];
    logic [11:0] dq[$];

    always #10 clk = ~clk;

    cfgcw_unpacker i_cfgcw_unpacker (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data),
        .dec_active(dec_active), .acw_valid(acw_valid), .acw_data(acw_data), .acw_ready(acw_ready),
        .dcw_valid(dcw_valid), .dcw_data(dcw_data), .dcw_ready(dcw_ready), .ovf_err(ovf_err)
    );

    always @(posedge clk) begin
        if (acw_valid && acw_ready) aq.push_back(acw_data);
        if (dcw_valid && dcw_ready) dq.push_back(dcw_data);
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(logic [23:0] w);
        @(negedge clk);
        bus_wr = 1'b1;
        {bus_addr, bus_data} = w;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic begin_run(logic [7:0] n);
        aq.delete();
        dq.delete();
        put({16'hFFF0, n});
    endtask

    task automatic drain();
        acw_ready = 1'b1;
        dcw_ready = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 active", dec_active, 0);
        chk("R1 acw_valid", acw_valid, 0);
        chk("R1 dcw_valid", dcw_valid, 0);
        chk("R1 ovf_err", ovf_err, 0);
    endtask

    task automatic t_idle();
        aq.delete();
        dq.delete();
        put(24'h123405);
        chk("R2 plain write stays idle", dec_active, 0);
        put(24'hFFF000);
        chk("R2 zero count stays idle", dec_active, 0);
        drain();
        chk("R2 no codewords", aq.size() + dq.size(), 0);
    endtask

    task automatic t_basic();
        begin_run(8'd4);
        chk("R2 start", dec_active, 1);
        put(24'h123419);
        chk("R4 still active", dec_active, 1);
        put(24'hAB2CD2);
        chk("R7 released", dec_active, 0);
        drain();
        chk("R5 addr count", aq.size(), 1);
        if (aq.size() == 1) chk("R3 addr word", aq[0], 24'h123419);
        chk("R10 data count", dq.size(), 2);
        if (dq.size() == 2) begin
            chk("R10 data first", dq[0], 12'hAB2);
            chk("R10 data second", dq[1], 12'hCD2);
        end
    endtask

    task automatic t_straddle();
        begin_run(8'd3);
        put(24'h0F0002);
        put(24'hFFFFFF);
        chk("R6 noop keeps active", dec_active, 1);
        put(24'h110567);
        chk("R4 pending half keeps active", dec_active, 1);
        put(24'h808222);
        chk("R7 released", dec_active, 0);
        drain();
        chk("R6 addr count", aq.size(), 2);
        if (aq.size() == 2) begin
            chk("R4 addr first", aq[0], 24'h0F0002);
            chk("R4 straddled addr", aq[1], 24'h567808);
        end
        chk("R6 data count", dq.size(), 2);
        if (dq.size() == 2) begin
            chk("R5 data first", dq[0], 12'h110);
            chk("R5 data second", dq[1], 12'h222);
        end
    endtask

    task automatic t_trailing();
        begin_run(8'd2);
        put(24'hBEEF08);
        put(24'h3329A5);
        chk("R7 released early", dec_active, 0);
        put(24'h123456);
        drain();
        chk("R7 addr count", aq.size(), 1);
        chk("R7 data count", dq.size(), 1);
        if (dq.size() == 1) chk("R7 data kept", dq[0], 12'h332);
    endtask

    task automatic t_overflow();
        dcw_ready = 1'b0;
        begin_run(8'd4);
        put(24'h010019);
        put(24'h440550);
        chk("R9 no error yet", ovf_err, 0);
        put(24'h660770);
        chk("R9 overflow flagged", ovf_err, 1);
        chk("R9 run ends", dec_active, 0);
        drain();
        chk("R9 sticky", ovf_err, 1);
        chk("R9 data count", dq.size(), 2);
        if (dq.size() == 2) begin
            chk("R8 order first", dq[0], 12'h440);
            chk("R8 order second", dq[1], 12'h550);
        end
    endtask

    task automatic t_pop_push();
        dcw_ready = 1'b0;
        begin_run(8'd4);
        chk("R9 cleared at start", ovf_err, 0);
        put(24'h020011);
        put(24'h440550);
        chk("R8 held valid", dcw_valid, 1);
        chk("R8 held head", dcw_data, 12'h440);
        @(negedge clk);
        dcw_ready = 1'b1;
        bus_wr = 1'b1;
        {bus_addr, bus_data} = 24'h660C0D;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 pop frees slot", ovf_err, 0);
        put(24'hE04880);
        chk("R7 released", dec_active, 0);
        drain();
        chk("R9 no error", ovf_err, 0);
        chk("R8 data count", dq.size(), 4);
        if (dq.size() == 4) begin
            chk("R8 d0", dq[0], 12'h440);
            chk("R8 d1", dq[1], 12'h550);
            chk("R8 d2", dq[2], 12'h660);
            chk("R8 d3", dq[3], 12'h880);
        end
        chk("R4 addr count", aq.size(), 2);
        if (aq.size() == 2) chk("R4 second addr", aq[1], 24'hC0DE04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_basic();
        t_straddle();
        t_trailing();
        t_overflow();
        t_pop_push();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule